// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage integer pipeline (fetch, decode, execute, memory, writeback) with a 64-bit datapath deals with data and control hazards. The pipeline has no structural hazards. The unit reads the source registers of the instruction in decode and the destination registers of the three older instructions. From these it raises a stall that holds fetch and decode and puts a bubble into execute. It also chooses, for each execute operand, where the operand comes from: the register file or a bypass from one of the three older stages. It flushes fetch while a control-transfer penalty is being paid.

A two-bit run-time mode selects one of three policies. The first is pure interlock: there is no bypassing, so every read-after-write dependency stalls. The second is bypassing with control transfers resolved late, so every accepted transfer costs three fetch-flush cycles. The third is bypassing with branch compare and target computation done in decode. In the third mode only a taken transfer costs a flush, and it costs one cycle.

The datapath, register file, ALU and memories are outside this block. The unit only drives their control signals.

Top module: `hazard_ctrl`

## Requirements
- R1: While rst_n is low, stall, bubble and flush_if are 0 and both forwarding selects are 2'b00 (register file), whatever the other inputs are.
- R2: In mode 2'b00, stall and bubble are 1 exactly when a read-enabled non-zero decode source equals the destination of a write-enabled instruction in execute, memory or writeback. Both selects stay 2'b00.
- R3: In modes 2'b01, 2'b10 and 2'b11, each select is 2'b01 for a match in execute, 2'b10 for a match in memory, 2'b11 for a match in writeback and 2'b00 for no match. The youngest match wins. A match needs the operand's read enable, the producer's write enable and equal non-zero addresses.
- R4: In mode 2'b01, stall is 1 only when the execute instruction is a write-enabled load whose destination matches a read-enabled non-zero decode source.
- R5: Register 0 never causes a stall and never gets a select other than 2'b00.
- R6: In modes 2'b00 and 2'b01, an accepted control transfer makes flush_if 1 for exactly the 3 cycles that follow. A transfer is accepted when it is in decode, stall is 0 and flush_if is 0.
- R7: In mode 2'b10, an accepted taken transfer makes flush_if 1 for exactly the next cycle. An accepted not-taken transfer causes no flush.
- R8: In mode 2'b10, a control transfer in decode stalls when a source matches the execute destination, or matches the memory destination of a load. Both need the producer's write enable and the source read enable.
- R9: Mode 2'b11 behaves exactly like mode 2'b10.
- R10: A control transfer is not accepted while it is stalled. Its penalty starts only after the cycle in which it is accepted.
- R11: bubble always equals stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Hazard policy: 00 interlock, 01 bypass, 10/11 bypass with decode-stage branch |
| id_rs1 | input | 5 | First source register of decode instruction |
| id_rs2 | input | 5 | Second source register of decode instruction |
| id_re1 | input | 1 | First source is read |
| id_re2 | input | 1 | Second source is read |
| id_cti | input | 1 | Decode instruction is a branch or jump |
| id_taken | input | 1 | Transfer in decode is taken (used in decode-branch mode) |
| ex_rd | input | 5 | Destination of execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination of memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination of writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| stall | output | 1 | Hold fetch and decode |
| bubble | output | 1 | Insert a bubble into execute |
| fwd_a | output | 2 | Operand 1 source: 00 regfile, 01 execute, 10 memory, 11 writeback |
| fwd_b | output | 2 | Operand 2 source, same encoding |
| flush_if | output | 1 | Discard the fetched instruction |

## Verification
Most of the outputs are combinational, so a wrong match or priority shows at the ports in the same cycle as the stimulus. The only state is the penalty counter. If it is wrong, flush_if has the wrong length after a transfer is accepted. It can also show as a transfer that is accepted during a flush or during a stall. Such errors appear one to three cycles after acceptance. The bench compares every output against a behavioural model on every cycle, so a counter slip is caught at the first cycle where the flush length differs.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int RW       = 5,
  parameter int SLOW_PEN = 3,
  parameter int FAST_PEN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_re1,
  input  logic          id_re2,
  input  logic          id_cti,
  input  logic          id_taken,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  output logic          stall,
  output logic          bubble,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          flush_if
);
  localparam int CW = $clog2(SLOW_PEN + 1);

  function automatic logic hit(input logic [RW-1:0] rs, input logic re,
                               input logic [RW-1:0] rd, input logic we);
    return re && we && (rs != '0) && (rs == rd);
  endfunction

  function automatic logic [1:0] pick(input logic e, input logic m, input logic w);
    return e ? 2'b01 : m ? 2'b10 : w ? 2'b11 : 2'b00;
  endfunction

  logic a_ex, a_mem, a_wb, b_ex, b_mem, b_wb;
  assign a_ex  = hit(id_rs1, id_re1, ex_rd,  ex_we);
  assign a_mem = hit(id_rs1, id_re1, mem_rd, mem_we);
  assign a_wb  = hit(id_rs1, id_re1, wb_rd,  wb_we);
  assign b_ex  = hit(id_rs2, id_re2, ex_rd,  ex_we);
  assign b_mem = hit(id_rs2, id_re2, mem_rd, mem_we);
  assign b_wb  = hit(id_rs2, id_re2, wb_rd,  wb_we);

  logic fwd_on, early, interlock, load_use, br_wait, stall_raw;
  assign fwd_on    = mode != 2'b00;
  assign early     = mode[1];
  assign interlock = a_ex | a_mem | a_wb | b_ex | b_mem | b_wb;
  assign load_use  = ex_load & (a_ex | b_ex);
  assign br_wait   = early & id_cti & (a_ex | b_ex | (mem_load & (a_mem | b_mem)));
  assign stall_raw = fwd_on ? (load_use | br_wait) : interlock;

  logic [CW-1:0] pen_cnt;
  logic          busy, accept;
  logic [CW-1:0] pen_load;
  assign busy     = pen_cnt != '0;
  assign accept   = id_cti & ~stall_raw & ~busy;
  assign pen_load = early ? (id_taken ? CW'(FAST_PEN) : '0) : CW'(SLOW_PEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pen_cnt <= '0;
    else if (accept) pen_cnt <= pen_load;
    else if (busy)   pen_cnt <= pen_cnt - 1'b1;
  end

  assign stall    = rst_n & stall_raw;
  assign bubble   = stall;
  assign fwd_a    = (rst_n && fwd_on) ? pick(a_ex, a_mem, a_wb) : 2'b00;
  assign fwd_b    = (rst_n && fwd_on) ? pick(b_ex, b_mem, b_wb) : 2'b00;
  assign flush_if = busy;

  AST_SLOW_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !early |=> flush_if && pen_cnt == CW'(SLOW_PEN)); // R6
  AST_FAST_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && early && id_taken |=> flush_if ##1 !flush_if); // R7
  AST_NOT_TAKEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && early && !id_taken |=> !flush_if); // R7
  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
    id_rs1 == '0 |-> fwd_a == 2'b00); // R5
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
    id_rs2 == '0 |-> fwd_b == 2'b00); // R5
  AST_FWD_NO_ALU_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 && !ex_load |-> !stall); // R4
  AST_NO_ACCEPT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    id_cti && stall && !flush_if |=> !flush_if); // R10
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode;
  logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic id_re1, id_re2, id_cti, id_taken, ex_we, ex_load, mem_we, mem_load, wb_we;
  logic stall, bubble, flush_if;
  logic [1:0] fwd_a, fwd_b;

  always #5 clk = ~clk;

  hazard_ctrl u_dut (.*);

  int errors = 0, checks = 0, mcnt = 0;
  bit m_accept, done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit mh(logic [4:0] rs, logic re, logic [4:0] rd, logic we);
    return re && we && rs != 0 && rs == rd;
  endfunction

  function automatic int msel(logic [4:0] rs, logic re);
    if (mode == 0) return 0;
    if (mh(rs, re, ex_rd, ex_we)) return 1;
    if (mh(rs, re, mem_rd, mem_we)) return 2;
    if (mh(rs, re, wb_rd, wb_we)) return 3;
    return 0;
  endfunction

  task automatic clr();
    mode = 0; id_rs1 = 0; id_rs2 = 0; id_re1 = 0; id_re2 = 0; id_cti = 0; id_taken = 0;
    ex_rd = 0; ex_we = 0; ex_load = 0; mem_rd = 0; mem_we = 0; mem_load = 0; wb_rd = 0; wb_we = 0;
  endtask

  task automatic settle();
    bit ea, eb, s;
    #4;
    ea = mh(id_rs1, id_re1, ex_rd, ex_we) || mh(id_rs2, id_re2, ex_rd, ex_we);
    eb = mh(id_rs1, id_re1, mem_rd, mem_we) || mh(id_rs2, id_re2, mem_rd, mem_we);
    if (mode == 0)
      s = ea || eb || mh(id_rs1, id_re1, wb_rd, wb_we) || mh(id_rs2, id_re2, wb_rd, wb_we);
    else
      s = (ex_load && ea) || (mode[1] && id_cti && (ea || (mem_load && eb)));
    chk(mode == 0 ? "R2" : "R4_R8", stall, s);
    chk("R11", bubble, s);
    chk("R3", fwd_a, msel(id_rs1, id_re1));
    chk("R3", fwd_b, msel(id_rs2, id_re2));
    chk(mode[1] ? "R7" : "R6", flush_if, mcnt != 0);
    m_accept = id_cti && !s && mcnt == 0;
  endtask

  task automatic adv();
    @(posedge clk);
    if (m_accept) mcnt = mode[1] ? (id_taken ? 1 : 0) : 3;
    else if (mcnt > 0) mcnt--;
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clr();
    mode = 0; id_rs1 = 5; id_re1 = 1; ex_rd = 5; ex_we = 1; id_cti = 1;
    mode = 1; id_rs2 = 6; id_re2 = 1; mem_rd = 6; mem_we = 1;
    #12;
    chk("R1", stall, 0); chk("R1", bubble, 0); chk("R1", flush_if, 0);
    chk("R1", fwd_a, 0); chk("R1", fwd_b, 0);
    @(negedge clk); rst_n = 1; clr(); @(negedge clk);

    // R2 interlock on each producer stage
    clr(); id_rs1 = 5; id_re1 = 1; ex_rd = 5; ex_we = 1; settle(); chk("R2", stall, 1); adv();
    clr(); id_rs2 = 7; id_re2 = 1; wb_rd = 7; wb_we = 1; settle(); chk("R2", stall, 1); chk("R2", fwd_b, 0); adv();
    clr(); id_rs1 = 5; id_re1 = 0; ex_rd = 5; ex_we = 1; settle(); chk("R2", stall, 0); adv();
    // R3 priority
    clr(); mode = 1; id_rs1 = 5; id_re1 = 1; ex_rd = 5; ex_we = 1; mem_rd = 5; mem_we = 1; wb_rd = 5; wb_we = 1;
    settle(); chk("R3", fwd_a, 1); chk("R3", stall, 0); adv();
    ex_we = 0; settle(); chk("R3", fwd_a, 2); adv();
    mem_we = 0; settle(); chk("R3", fwd_a, 3); adv();
    // R5 register zero
    clr(); id_rs1 = 0; id_re1 = 1; ex_we = 1; settle(); chk("R5", stall, 0); adv();
    mode = 1; settle(); chk("R5", fwd_a, 0); adv();
    // R4 load-use
    clr(); mode = 1; id_rs2 = 9; id_re2 = 1; ex_rd = 9; ex_we = 1; ex_load = 1; settle(); chk("R4", stall, 1); adv();
    // R8 branch waits on execute, and on a load in memory
    clr(); mode = 2; id_cti = 1; id_rs1 = 4; id_re1 = 1; ex_rd = 4; ex_we = 1; settle(); chk("R8", stall, 1); adv();
    // R10 stalled transfer not accepted: no flush
    settle(); chk("R10", flush_if, 0);
    ex_we = 0; mem_rd = 4; mem_we = 1; mem_load = 1; adv(); settle(); chk("R8", stall, 1); adv();
    mem_load = 0; id_taken = 1; settle(); chk("R10", stall, 0); adv();
    clr(); settle(); chk("R7", flush_if, 1); adv();
    settle(); chk("R7", flush_if, 0); adv();
    // R7 not taken
    clr(); mode = 2; id_cti = 1; settle(); adv(); clr(); mode = 2; settle(); chk("R7", flush_if, 0); adv();
    // R9 mode 3 taken
    clr(); mode = 3; id_cti = 1; id_taken = 1; settle(); adv(); clr(); mode = 3;
    settle(); chk("R9", flush_if, 1); adv(); settle(); chk("R9", flush_if, 0); adv();
    // R6 slow penalty
    clr(); id_cti = 1; settle(); adv(); clr();
    for (int i = 0; i < 3; i++) begin settle(); chk("R6", flush_if, 1); adv(); end
    settle(); chk("R6", flush_if, 0); adv();

    for (int n = 0; n < 4000; n++) begin
      mode = 2'($urandom); id_rs1 = 5'($urandom % 4); id_rs2 = 5'($urandom % 4);
      id_re1 = 1'($urandom); id_re2 = 1'($urandom); id_cti = ($urandom % 4) == 0; id_taken = 1'($urandom);
      ex_rd = 5'($urandom % 4); ex_we = 1'($urandom); ex_load = 1'($urandom);
      mem_rd = 5'($urandom % 4); mem_we = 1'($urandom); mem_load = 1'($urandom);
      wb_rd = 5'($urandom % 4); wb_we = 1'($urandom);
      settle(); adv();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule